// File: doc/BRIEF.md
# SPI flash command sequencer

This block is a register-programmed SPI flash master. Software loads a menu of eight one-byte opcodes, a type word saying how each one behaves, a 24-bit flash address and up to 64 bytes of data. It then writes a control word that picks one menu entry and sets the go bit. The block runs a single command cycle on a single-lane mode-0 SPI bus. The cycle sends the opcode, then three address bytes if the entry's type needs them, then the data bytes. For a write type the data comes from the buffer. For a read type the data is captured into the buffer.

A prefix opcode, typically a write-enable, can be sent as a separate chip-select frame just before the main command. No other cycle can run between the two. A lock bit freezes the opcode configuration until reset. A lower address bound rejects addressed commands that fall below it, and such a command never touches the bus.

All registers sit on a plain one-cycle write port and a combinational read port. Completion is reported through sticky status bits that software polls and clears.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset, status (offset 0) and control (offset 1) read 0, chip select `spi_cs_n` is high and `spi_sck` is low.
- R2: Status bit 0 (busy) reads 1 from the clock edge that accepts a control write with bit 1 (go) set. It returns to 0 in the same cycle that done (bit 2) or error (bit 3) is set. A go written while busy is 1 is ignored, and so is the rest of that control write.
- R3: Done (status bit 2) and error (status bit 3) stay set until software writes 1 to that bit. Writing 0 to them has no effect.
- R4: The control register (offset 1) holds go at bit 1, prefix enable at bit 2, menu index at bits 6:4, data byte count minus one at bits 13:8, and data phase enable at bit 14.
- R5: The first byte of the main frame is the menu entry chosen by the index. Offset 4 holds entries 0 to 3 and offset 5 holds entries 4 to 7, with entry i in byte i mod 4. The type word at offset 6 gives entry i a 2-bit type at bits 2i+1:2i, coded 0 = read without address, 1 = write without address, 2 = read with address, 3 = write with address.
- R6: Types 2 and 3 send the 24-bit address from offset 2 right after the opcode, most significant byte first. Types 0 and 1 send no address.
- R7: With the data phase enabled, count+1 data bytes follow (1 to 64). Read types send 0x00 and store each received byte into the buffer starting at byte 0. Write types send buffer bytes starting at byte 0. Buffer word w sits at offset 16+w and holds bytes 4w..4w+3, with the lowest byte in bits 7:0.
- R8: With the data phase disabled, the frame ends after the opcode and any address, and done is set.
- R9: With prefix enable set, the prefix opcode (offset 7, bits 7:0) is sent as a frame of its own. Chip select then stays high for at least two SCK periods, and the main frame follows.
- R10: Writing 1 to status bit 15 sets the lock, which reads back at bit 15. While it is set, writes to offsets 4, 5, 6 and 7 are ignored. Only reset clears it.
- R11: The address floor (offset 3) keeps bits 23:8 only. A type 2 or 3 command whose address is below the floor sets error and produces no chip-select activity.
- R12: SPI mode 0: SCK idles low, bits go MSB first, MISO is sampled on the rising edge, and each SCK phase lasts `SCK_HALF` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 5 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench uses the defaults: `SCK_HALF` = 2 and a 64-byte buffer. The short divider keeps one byte at about 34 clock cycles. That is cheap enough to walk all eight menu entries and to sweep the byte count from 1 to 64 in both directions, so the full-buffer boundary and the word-straddling counts are all reached. A flash model in the bench records every frame and answers with a byte pattern computed from the byte's position. Expected opcodes, addresses, buffer contents, the prefix gap and the SCK pulse width are all derived from that arithmetic.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {PH_PRE, PH_OPC, PH_ADR, PH_DAT} phase_t;
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_LOAD, S_WAIT, S_GAP} state_t;

  localparam logic [4:0] RA_STATUS  = 5'd0;
  localparam logic [4:0] RA_CTRL    = 5'd1;
  localparam logic [4:0] RA_ADDR    = 5'd2;
  localparam logic [4:0] RA_FLOOR   = 5'd3;
  localparam logic [4:0] RA_MENU_LO = 5'd4;
  localparam logic [4:0] RA_MENU_HI = 5'd5;
  localparam logic [4:0] RA_TYPES   = 5'd6;
  localparam logic [4:0] RA_PREFIX  = 5'd7;

  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 2;
  localparam int SB_ERR  = 3;
  localparam int SB_LOCK = 15;

  localparam int CB_GO     = 1;
  localparam int CB_ATOMIC = 2;
  localparam int CB_IDX    = 4;
  localparam int CB_CNT    = 8;
  localparam int CB_DPHASE = 14;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic          active;
  logic [7:0]    sh;
  logic [2:0]    bits;
  logic [DW-1:0] div;

  assign mosi = active & sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sh     <= '0;
      bits   <= '0;
      div    <= '0;
      sck    <= 1'b0;
      done   <= 1'b0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        sh     <= tx;
        bits   <= '0;
        div    <= '0;
        sck    <= 1'b0;
      end else if (active) begin
        if (div == DW'(SCK_HALF - 1)) begin
          div <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            sh  <= {sh[6:0], 1'b0};
            if (bits == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bits <= bits + 3'd1;
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_data_buf.sv
module spi_data_buf #(
  parameter int BYTES = 64
) (
  input  logic                        clk,
  input  logic                        sw_we,
  input  logic [$clog2(BYTES/4)-1:0]  sw_widx,
  input  logic [31:0]                 sw_wdata,
  input  logic [$clog2(BYTES/4)-1:0]  sw_ridx,
  output logic [31:0]                 sw_rdata,
  input  logic                        en_we,
  input  logic [$clog2(BYTES)-1:0]    en_idx,
  input  logic [7:0]                  en_wdata,
  output logic [7:0]                  en_rdata
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (sw_we) begin
      for (int k = 0; k < 4; k++) mem[{sw_widx, 2'(k)}] <= sw_wdata[8*k +: 8];
    end
    if (en_we) mem[en_idx] <= en_wdata;
  end

  always_comb begin
    for (int k = 0; k < 4; k++) sw_rdata[8*k +: 8] = mem[{sw_ridx, 2'(k)}];
  end

  assign en_rdata = mem[en_idx];
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int SCK_HALF   = 2,
  parameter int DATA_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [4:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int CNT_W   = $clog2(DATA_BYTES);
  localparam int WIDX_W  = $clog2(DATA_BYTES / 4);
  localparam int GAP_CYC = 4 * SCK_HALF;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  logic             st_busy, st_done, st_err, locked;
  logic [23:0]      addr_q;
  logic [15:0]      floor_q;
  logic [63:0]      menu_q;
  logic [15:0]      types_q;
  logic [7:0]       prefix_q;
  logic             ctl_atomic, ctl_dphase;
  logic [2:0]       ctl_idx;
  logic [CNT_W-1:0] ctl_cnt;
  state_t           state;
  phase_t           ph;
  logic [CNT_W-1:0] bidx;
  logic [1:0]       kind;
  logic [GAP_W-1:0] gcnt;
  logic             cs_q;

  logic       sh_start, sh_done;
  logic [7:0] sh_tx, sh_rx, buf_byte;
  logic [31:0] buf_word;
  logic       go_req, buf_sw_we, buf_en_we;

  assign go_req    = reg_we && (reg_waddr == RA_CTRL) && reg_wdata[CB_GO] && !st_busy;
  assign buf_sw_we = reg_we && reg_waddr[4] && !st_busy;
  assign buf_en_we = (state == S_WAIT) && sh_done && (ph == PH_DAT) && !kind[0];
  assign sh_start  = (state == S_LOAD);
  assign spi_cs_n  = cs_q;

  always_comb begin
    unique case (ph)
      PH_PRE: sh_tx = prefix_q;
      PH_OPC: sh_tx = menu_q[{ctl_idx, 3'b000} +: 8];
      PH_ADR: sh_tx = (bidx[1:0] == 2'd0) ? addr_q[23:16] :
                      (bidx[1:0] == 2'd1) ? addr_q[15:8] : addr_q[7:0];
      PH_DAT: sh_tx = kind[0] ? buf_byte : 8'h00;
    endcase
  end

  spi_byte_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
  );

  spi_data_buf #(.BYTES(DATA_BYTES)) u_buf (
    .clk(clk), .sw_we(buf_sw_we), .sw_widx(reg_waddr[WIDX_W-1:0]), .sw_wdata(reg_wdata),
    .sw_ridx(reg_raddr[WIDX_W-1:0]), .sw_rdata(buf_word),
    .en_we(buf_en_we), .en_idx(bidx), .en_wdata(sh_rx), .en_rdata(buf_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_busy <= 1'b0; st_done <= 1'b0; st_err <= 1'b0; locked <= 1'b0;
      addr_q <= '0; floor_q <= '0; menu_q <= '0; types_q <= '0; prefix_q <= '0;
      ctl_atomic <= 1'b0; ctl_dphase <= 1'b0; ctl_idx <= '0; ctl_cnt <= '0;
      state <= S_IDLE; ph <= PH_OPC; bidx <= '0; kind <= '0; gcnt <= '0; cs_q <= 1'b1;
    end else begin
      // software side; engine updates below take priority
      if (reg_we) begin
        unique case (reg_waddr)
          RA_STATUS: begin
            if (reg_wdata[SB_DONE]) st_done <= 1'b0;
            if (reg_wdata[SB_ERR])  st_err  <= 1'b0;
            if (reg_wdata[SB_LOCK]) locked  <= 1'b1;
          end
          RA_CTRL: if (!st_busy) begin
            ctl_atomic <= reg_wdata[CB_ATOMIC];
            ctl_idx    <= reg_wdata[CB_IDX +: 3];
            ctl_cnt    <= reg_wdata[CB_CNT +: CNT_W];
            ctl_dphase <= reg_wdata[CB_DPHASE];
          end
          RA_ADDR:    if (!st_busy) addr_q <= reg_wdata[23:0];
          RA_FLOOR:   floor_q <= reg_wdata[23:8];
          RA_MENU_LO: if (!locked) menu_q[31:0]  <= reg_wdata;
          RA_MENU_HI: if (!locked) menu_q[63:32] <= reg_wdata;
          RA_TYPES:   if (!locked) types_q  <= reg_wdata[15:0];
          RA_PREFIX:  if (!locked) prefix_q <= reg_wdata[7:0];
          default: ;
        endcase
      end
      unique case (state)
        S_IDLE: if (go_req) begin
          st_busy <= 1'b1;
          kind    <= types_q[{reg_wdata[CB_IDX +: 3], 1'b0} +: 2];
          state   <= S_CHECK;
        end
        S_CHECK: begin
          if (kind[1] && (addr_q[23:8] < floor_q)) begin
            st_err  <= 1'b1;
            st_busy <= 1'b0;
            state   <= S_IDLE;
          end else begin
            ph    <= ctl_atomic ? PH_PRE : PH_OPC;
            bidx  <= '0;
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          cs_q  <= 1'b0;
          state <= S_WAIT;
        end
        S_WAIT: if (sh_done) begin
          state <= S_LOAD;
          unique case (ph)
            PH_PRE: begin
              cs_q <= 1'b1; gcnt <= '0; ph <= PH_OPC; state <= S_GAP;
            end
            PH_OPC: begin
              bidx <= '0;
              if (kind[1]) ph <= PH_ADR;
              else if (ctl_dphase) ph <= PH_DAT;
              else begin
                cs_q <= 1'b1; st_busy <= 1'b0; st_done <= 1'b1; state <= S_IDLE;
              end
            end
            PH_ADR: begin
              if (bidx != CNT_W'(2)) bidx <= bidx + CNT_W'(1);
              else if (ctl_dphase) begin
                ph <= PH_DAT; bidx <= '0;
              end else begin
                cs_q <= 1'b1; st_busy <= 1'b0; st_done <= 1'b1; state <= S_IDLE;
              end
            end
            PH_DAT: begin
              if (bidx != ctl_cnt) bidx <= bidx + CNT_W'(1);
              else begin
                cs_q <= 1'b1; st_busy <= 1'b0; st_done <= 1'b1; state <= S_IDLE;
              end
            end
          endcase
        end
        S_GAP: begin
          if (gcnt == GAP_W'(GAP_CYC - 1)) state <= S_LOAD;
          else gcnt <= gcnt + GAP_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr[4]) reg_rdata = buf_word;
    else begin
      unique case (reg_raddr)
        RA_STATUS: begin
          reg_rdata[SB_BUSY] = st_busy;
          reg_rdata[SB_DONE] = st_done;
          reg_rdata[SB_ERR]  = st_err;
          reg_rdata[SB_LOCK] = locked;
        end
        RA_CTRL: begin
          reg_rdata[CB_ATOMIC]       = ctl_atomic;
          reg_rdata[CB_IDX +: 3]     = ctl_idx;
          reg_rdata[CB_CNT +: CNT_W] = ctl_cnt;
          reg_rdata[CB_DPHASE]       = ctl_dphase;
        end
        RA_ADDR:    reg_rdata[23:0] = addr_q;
        RA_FLOOR:   reg_rdata[23:8] = floor_q;
        RA_MENU_LO: reg_rdata = menu_q[31:0];
        RA_MENU_HI: reg_rdata = menu_q[63:32];
        RA_TYPES:   reg_rdata[15:0] = types_q;
        RA_PREFIX:  reg_rdata[7:0] = prefix_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic locked,
  input logic cs_n,
  input logic sck
);
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked);
  // R2
  busy_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done || err));
  // R2
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
  // R11
  floor_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> (cs_n && $past(cs_n)));
  // R12
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
endmodule

bind spi_cmd_seq spi_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(st_busy), .done(st_done), .err(st_err),
  .locked(locked), .cs_n(spi_cs_n), .sck(spi_sck)
);

// File: tb/test_spi_cmd_seq.sv
module test_spi_cmd_seq;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [4:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0, errors = 0, cyc = 0;

  spi_cmd_seq #(.SCK_HALF(HALF), .DATA_BYTES(64)) i_spi_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #4 clk = ~clk;

  // ---------------- flash model ----------------
  function automatic logic [7:0] pat(int k);
    return 8'(k * 37 + 11);
  endfunction
  function automatic logic [7:0] wpat(int k);
    return 8'(k * 13 + 5);
  endfunction
  function automatic logic pat_bit(int p);
    logic [7:0] b;
    b = pat(p / 8);
    return b[7 - (p % 8)];
  endfunction

  logic [7:0] rec [256];
  int recfr [256];
  int nrec = 0, nfr = 0, bitpos = 0, hi_cnt = 0, last_gap = 0, sck_hi = 0, last_hi = 0;
  logic [7:0] sr = '0;

  assign spi_miso = pat_bit(bitpos);

  always @(negedge spi_cs_n) begin
    bitpos   = 0;
    nfr      = nfr + 1;
    last_gap = hi_cnt;
  end
  always @(posedge spi_sck) begin
    sr = {sr[6:0], spi_mosi};
    if ((bitpos % 8) == 7 && nrec < 256) begin
      rec[nrec] = sr; recfr[nrec] = nfr; nrec = nrec + 1;
    end
  end
  always @(negedge spi_sck) bitpos = bitpos + 1;
  always @(posedge clk) begin
    hi_cnt <= spi_cs_n ? hi_cnt + 1 : 0;
    if (spi_sck) sck_hi <= sck_hi + 1;
    else if (sck_hi != 0) begin last_hi <= sck_hi; sck_hi <= 0; end
  end

  // ---------------- helpers ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(int idx, int n, bit dph, bit atom);
    return (32'(dph) << 14) | (32'(n - 1) << 8) | (32'(idx) << 4) | (32'(atom) << 2) | 32'h2;
  endfunction

  function automatic logic [7:0] menu_b(int idx);
    logic [63:0] m;
    m = 64'hAB05200B_069F0203;
    return m[8*idx +: 8];
  endfunction

  task automatic clr();
    nrec = 0; nfr = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(5'd0, s);
      if (!s[0]) return;
      @(negedge clk);
    end
    check("R2 busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic run(logic [31:0] c);
    wr(5'd1, c);
    wait_idle();
  endtask

  task automatic do_read(int idx, logic [23:0] a, int n, bit has_a);
    int base, bad, badj;
    logic [31:0] w;
    clr(); wr(5'd2, {8'h0, a}); run(mk(idx, n, 1'b1, 1'b0));
    base = has_a ? 4 : 1;
    check($sformatf("R7 read frame length n=%0d", n), 32'(nrec), 32'(base + n));
    check("R5 read opcode", {24'h0, rec[0]}, {24'h0, menu_b(idx)});
    if (has_a) check("R6 read address bytes", {8'h0, rec[1], rec[2], rec[3]}, {8'h0, a});
    bad = 0; badj = 0;
    for (int j = 0; j < n; j++) begin
      rd(5'(16 + j / 4), w);
      if (w[8*(j%4) +: 8] !== pat(base + j) || rec[base + j] !== 8'h00) begin
        if (bad == 0) badj = j;
        bad++;
      end
    end
    check($sformatf("R7 read data n=%0d first bad byte %0d", n, badj), 32'(bad), 32'd0);
  endtask

  task automatic do_write(int idx, logic [23:0] a, int n);
    int bad;
    clr(); wr(5'd2, {8'h0, a}); run(mk(idx, n, 1'b1, 1'b0));
    check($sformatf("R7 write frame length n=%0d", n), 32'(nrec), 32'(4 + n));
    check("R6 write address bytes", {8'h0, rec[1], rec[2], rec[3]}, {8'h0, a});
    bad = 0;
    for (int j = 0; j < n; j++) if (rec[4 + j] !== wpat(j)) bad++;
    check($sformatf("R7 write data n=%0d", n), 32'(bad), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] s;
    int sweep [15] = '{1, 2, 3, 4, 5, 8, 15, 16, 17, 31, 32, 33, 48, 63, 64};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'd0, s); check("R1 status after reset", s, 32'h0);
    rd(5'd1, s); check("R1 control after reset", s, 32'h0);
    check("R1 cs_n idle high", {31'h0, spi_cs_n}, 32'h1);
    check("R1 sck idle low", {31'h0, spi_sck}, 32'h0);

    // program menu and types (R5)
    wr(5'd4, 32'h069F0203);
    wr(5'd5, 32'hAB05200B);
    wr(5'd6, 32'h00004E4E);
    rd(5'd5, s); check("R5 menu high readback", s, 32'hAB05200B);

    // R2 busy timing, go while busy ignored
    clr(); wr(5'd2, 32'h00102030);
    wr(5'd1, mk(0, 2, 1'b1, 1'b0));
    rd(5'd0, s); check("R2 busy set after go", {31'h0, s[0]}, 32'h1);
    wr(5'd1, mk(2, 1, 1'b1, 1'b0));
    rd(5'd1, s); check("R2 control write ignored while busy", s, mk(0, 2, 1'b1, 1'b0) & ~32'h2);
    wait_idle();
    check("R2 single frame despite second go", 32'(nfr), 32'd1);
    check("R2 first command kept", {24'h0, rec[0]}, 32'h03);
    rd(5'd0, s); check("R2 done set busy clear", s, 32'h4);
    // R3 write-one-to-clear
    wr(5'd0, 32'h0);
    rd(5'd0, s); check("R3 writing 0 keeps done", s, 32'h4);
    wr(5'd0, 32'h4);
    rd(5'd0, s); check("R3 writing 1 clears done", s, 32'h0);

    // R5/R6 sweep of all menu entries
    for (int i = 0; i < 8; i++) begin
      clr(); wr(5'd2, 32'h00A5C3E1); run(mk(i, 2, 1'b1, 1'b0));
      check($sformatf("R5 opcode entry %0d", i), {24'h0, rec[0]}, {24'h0, menu_b(i)});
      check($sformatf("R6 frame length entry %0d", i), 32'(nrec), (i % 4 < 2) ? 32'd6 : 32'd3);
    end

    // R7/R4 read sweeps
    foreach (sweep[k]) do_read(k % 2 == 0 ? 0 : 4, 24'(32'h010203 * (k + 1)), sweep[k], 1'b1);
    do_read(2, 24'h0, 3, 1'b0);
    do_read(6, 24'h0, 64, 1'b0);

    // R7 write sweeps
    for (int w = 0; w < 16; w++)
      wr(5'(16 + w), {wpat(4*w+3), wpat(4*w+2), wpat(4*w+1), wpat(4*w)});
    foreach (sweep[k]) do_write(k % 2 == 0 ? 1 : 5, 24'(32'hFEDCBA - k * 4099), sweep[k]);

    // R8 no data phase
    clr(); run(mk(3, 1, 1'b0, 1'b0));
    check("R8 opcode-only frame length", 32'(nrec), 32'd1);
    check("R8 opcode-only byte", {24'h0, rec[0]}, 32'h06);
    clr(); wr(5'd2, 32'h00778899); run(mk(0, 5, 1'b0, 1'b0));
    check("R8 address-only frame length", 32'(nrec), 32'd4);
    rd(5'd0, s); check("R8 done set", {31'h0, s[2]}, 32'h1);

    // R9 prefix frame
    wr(5'd7, 32'h06);
    clr(); wr(5'd2, 32'h00001000); run(mk(1, 4, 1'b1, 1'b1));
    check("R9 two frames", 32'(nfr), 32'd2);
    check("R9 prefix byte", {24'h0, rec[0]}, 32'h06);
    check("R9 prefix alone in frame 1", 32'(recfr[1]), 32'd2);
    check("R9 main opcode", {24'h0, rec[1]}, 32'h02);
    check("R9 gap at least two SCK periods", 32'(last_gap >= 4 * HALF), 32'd1);
    check("R12 SCK high phase width", 32'(last_hi), 32'(HALF));

    // R11 floor
    wr(5'd0, 32'hC);
    wr(5'd3, 32'h00123456);
    rd(5'd3, s); check("R11 floor keeps bits 23:8", s, 32'h00123400);
    clr(); wr(5'd2, 32'h001233FF); run(mk(0, 1, 1'b1, 1'b0));
    rd(5'd0, s); check("R11 below floor raises error", s, 32'h8);
    check("R11 below floor no frame", 32'(nfr), 32'd0);
    wr(5'd0, 32'h8);
    rd(5'd0, s); check("R3 error cleared by write one", s, 32'h0);
    clr(); wr(5'd2, 32'h00123400); run(mk(0, 1, 1'b1, 1'b0));
    check("R11 at floor runs", 32'(nfr), 32'd1);
    clr(); run(mk(2, 1, 1'b1, 1'b0));
    check("R11 unaddressed ignores floor", 32'(nfr), 32'd1);
    wr(5'd3, 32'h0);

    // R10 lock
    wr(5'd0, 32'h8000);
    rd(5'd0, s); check("R10 lock visible", {31'h0, s[15]}, 32'h1);
    wr(5'd4, 32'h0); wr(5'd6, 32'h0); wr(5'd7, 32'h55);
    rd(5'd4, s); check("R10 menu frozen", s, 32'h069F0203);
    rd(5'd6, s); check("R10 types frozen", s, 32'h4E4E);
    rd(5'd7, s); check("R10 prefix frozen", s, 32'h06);
    wr(5'd0, 32'h0000000C);
    rd(5'd0, s); check("R10 lock persists", {31'h0, s[15]}, 32'h1);
    clr(); wr(5'd2, 32'h00040000); run(mk(0, 1, 1'b1, 1'b0));
    check("R10 locked menu still used", {24'h0, rec[0]}, 32'h03);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule